// File: doc/BRIEF.md
# Unaligned Streaming Memory Read Port

This block lets a processor read a run of consecutive bytes from a 32-bit-wide memory, one byte, halfword (here "word", 16 bits) or 32-bit "long" at a time, starting at any byte position. A redirect command loads a 19-bit byte address. From then on the port fetches consecutive 32-bit longs from memory on its own and keeps a small queue of them topped up. Each consume command takes the next item from the current byte position, even when that item spans two longs. The item comes back zero-extended, together with a zero flag and the item's top bit.

The memory side is a plain request/response pair with a fixed read latency. Every request carries a generation tag, and the memory returns that tag with the data. A redirect bumps the generation. Responses that were in flight from the old stream are recognised on return and dropped. A redirect is held off while the surrounding logic reports that writes are still pending. The port never arbitrates memory and never performs a lone random access.

Top module: `hub_stream_rdport`

## Requirements
- R1: After a redirect is accepted, the first memory request uses long address `start_addr[18:2]`, and the first item begins at byte `start_addr[1:0]` of that long.
- R2: While `wr_busy` is high, `start_ready` is low and a pending redirect has no effect. The redirect is accepted in the first cycle in which `wr_busy` is low.
- R3: An accepted redirect discards every long already queued. A response whose tag differs from the current generation is never queued. Items after a redirect come only from the new address.
- R4: `take_size` encoding: 2'b00 is a byte, 2'b01 is a word, 2'b10 and 2'b11 are a long. An accepted item advances the byte cursor by 1, 2 or 4. Item byte k (bits 8k+7:8k) is the memory byte at cursor+k, with byte j of a long held in bits 8j+7:8j. Bits above the item's size read as zero.
- R5: An item that runs past the end of the current long is completed from the next consecutive long.
- R6: `take_zero` is high exactly when the returned item equals zero.
- R7: `take_msb` equals bit 7, 15 or 31 of the item for a byte, word or long.
- R8: `take_ready` is low whenever the queued bytes beyond the cursor are fewer than the item size, and also while `start_valid` is high. `take_data` and the flags stay valid until the item is accepted.
- R9: A request is issued in every cycle in which stored plus in-flight longs number fewer than 8, and never otherwise. With no consumption, exactly 8 requests follow a redirect.
- R10: Successive requests use consecutive long addresses, wrapping from 17'h1FFFF to 0.
- R11: After reset, and until the first redirect, no request is issued, `take_ready` is low and `start_ready` follows `!wr_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_busy | input | 1 | Writes still pending elsewhere; blocks redirects |
| start_valid | input | 1 | Redirect command present |
| start_addr | input | 19 | Redirect byte address |
| start_ready | output | 1 | Redirect accepted this cycle when high |
| take_valid | input | 1 | Consume command present |
| take_size | input | 2 | Item size code |
| take_ready | output | 1 | Item available; accepted when take_valid is also high |
| take_data | output | 32 | Zero-extended item |
| take_zero | output | 1 | Item equals zero |
| take_msb | output | 1 | Top bit of the item |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 17 | Long address of the request |
| mem_tag | output | 3 | Generation tag sent with the request |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Returned long |
| mem_rtag | input | 3 | Tag echoed with the data |

## Verification
The bench builds the port with its defaults: an 8-long queue and a read latency of 3, which gives a 3-bit generation tag. That queue is shallow enough that it fills within about a dozen cycles. Every start offset 0 to 11 can then be swept against every item size, and mixed-size sequences walk the cursor through all four byte positions and every straddle. The short latency keeps responses in flight across back-to-back redirects, so tag filtering gets exercised. A start just below the top of the 19-bit space reaches the address wrap within one item.

// File: rtl/hsr_pkg.sv
package hsr_pkg;

  localparam int LONG_BITS = 32;

  // number of bytes covered by an item of the given size code
  function automatic logic [2:0] item_bytes(input logic [1:0] sz);
    case (sz)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // mask selecting the valid bits of a zero-extended item
  function automatic logic [LONG_BITS-1:0] item_mask(input logic [1:0] sz);
    case (sz)
      2'b00:   return 32'h0000_00FF;
      2'b01:   return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // take an item out of a two-long window starting at a byte cursor
  function automatic logic [LONG_BITS-1:0] pick_item(input logic [2*LONG_BITS-1:0] win,
                                                     input logic [1:0] cur,
                                                     input logic [1:0] sz);
    logic [2*LONG_BITS-1:0] sh;
    sh = win >> {cur, 3'b000};
    return sh[LONG_BITS-1:0] & item_mask(sz);
  endfunction

  // top bit of an item for its size
  function automatic logic item_top(input logic [LONG_BITS-1:0] it, input logic [1:0] sz);
    case (sz)
      2'b00:   return it[7];
      2'b01:   return it[15];
      default: return it[31];
    endcase
  endfunction

  // cursor plus item length; bit 2 means the head long is used up
  function automatic logic [2:0] cursor_sum(input logic [1:0] cur, input logic [1:0] sz);
    return {1'b0, cur} + item_bytes(sz);
  endfunction

endpackage

// File: rtl/hsr_prefetch_q.sv
module hsr_prefetch_q #(
  parameter int DEPTH  = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int WIDTH  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head0,
  output logic [WIDTH-1:0] head1,
  output logic [CNT_W-1:0] stored
);

  logic [DEPTH-1:0][WIDTH-1:0] slot_q;
  logic [DEPTH-1:0][WIDTH-1:0] slot_up;
  logic [CNT_W-1:0]            cnt_q;
  logic [CNT_W-1:0]            wr_idx;

  // each slot moves one place toward the head on a pop
  assign slot_up = slot_q >> WIDTH;
  assign wr_idx  = pop ? cnt_q - CNT_W'(1) : cnt_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && wr_idx == CNT_W'(i))
        slot_q[i] <= push_data;
      else if (pop)
        slot_q[i] <= slot_up[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush)
      cnt_q <= '0;
    else if (push && !pop)
      cnt_q <= cnt_q + CNT_W'(1);
    else if (pop && !push)
      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign head0  = slot_q[0];
  assign head1  = slot_q[1];
  assign stored = cnt_q;

endmodule

// File: rtl/hsr_fetch_ctl.sv
module hsr_fetch_ctl #(
  parameter int DEPTH  = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int LONG_W = 17,
  parameter int GEN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_fire,
  input  logic [LONG_W-1:0] start_long,
  input  logic [CNT_W-1:0]  stored,
  input  logic              rsp_valid,
  output logic              req,
  output logic [LONG_W-1:0] req_addr,
  output logic [GEN_W-1:0]  gen,
  output logic [CNT_W-1:0]  inflight
);

  logic              active_q;
  logic [LONG_W-1:0] addr_q;
  logic [GEN_W-1:0]  gen_q;
  logic [CNT_W-1:0]  fly_q;
  logic [CNT_W:0]    reserved;
  logic              room;

  // queue slots plus requests still travelling must leave a free slot
  assign reserved = (CNT_W+1)'(stored) + (CNT_W+1)'(fly_q);
  assign room     = reserved < (CNT_W+1)'(DEPTH);
  assign req      = active_q && room && !start_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      addr_q   <= '0;
      gen_q    <= '0;
    end else if (start_fire) begin
      active_q <= 1'b1;
      addr_q   <= start_long;
      gen_q    <= gen_q + GEN_W'(1);
    end else if (req) begin
      addr_q   <= addr_q + LONG_W'(1);
    end
  end

  // stale responses still come back, so they stay counted until they do
  always_ff @(posedge clk) begin
    if (!rst_n)
      fly_q <= '0;
    else if (req && !rsp_valid)
      fly_q <= fly_q + CNT_W'(1);
    else if (rsp_valid && !req)
      fly_q <= fly_q - CNT_W'(1);
  end

  assign req_addr = addr_q;
  assign gen      = gen_q;
  assign inflight = fly_q;

endmodule

// File: rtl/hsr_item_align.sv
module hsr_item_align #(
  parameter int CNT_W = 4
) (
  input  logic [31:0]      head0,
  input  logic [31:0]      head1,
  input  logic [1:0]       cursor,
  input  logic [1:0]       size,
  input  logic [CNT_W-1:0] stored,
  output logic [31:0]      item,
  output logic             zero,
  output logic             msb,
  output logic             enough,
  output logic             pop,
  output logic [1:0]       next_cursor
);
  import hsr_pkg::*;

  logic [2:0]       span;
  logic [CNT_W+1:0] avail;

  assign span        = cursor_sum(cursor, size);
  assign avail       = {stored, 2'b00};
  assign enough      = avail >= (CNT_W+2)'(span);
  assign pop         = span[2];
  assign next_cursor = span[1:0];
  assign item        = pick_item({head1, head0}, cursor, size);
  assign zero        = (item == '0);
  assign msb         = item_top(item, size);

endmodule

// File: rtl/hub_stream_rdport.sv
module hub_stream_rdport #(
  parameter int ADDR_W = 19,
  parameter int DEPTH  = 8,
  parameter int RD_LAT = 3,
  localparam int LONG_W = ADDR_W - 2,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int GEN_W  = $clog2(RD_LAT + 1) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_busy,
  input  logic              start_valid,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              start_ready,
  input  logic              take_valid,
  input  logic [1:0]        take_size,
  output logic              take_ready,
  output logic [31:0]       take_data,
  output logic              take_zero,
  output logic              take_msb,
  output logic              mem_req,
  output logic [LONG_W-1:0] mem_addr,
  output logic [GEN_W-1:0]  mem_tag,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  input  logic [GEN_W-1:0]  mem_rtag
);

  // named internal events, also watched by the checker
  logic             start_fire;
  logic             take_fire;
  logic             rsp_push;
  logic             adv_pop;
  logic             item_enough;
  logic [1:0]       cursor_q;
  logic [1:0]       cursor_nx;
  logic [CNT_W-1:0] stored_cnt;
  logic [CNT_W-1:0] inflight_cnt;
  logic [GEN_W-1:0] gen_q;
  logic [31:0]      head0;
  logic [31:0]      head1;

  assign start_ready = !wr_busy;
  assign start_fire  = start_valid && start_ready;
  assign take_ready  = item_enough && !start_valid;
  assign take_fire   = take_valid && take_ready;
  assign rsp_push    = mem_rvalid && (mem_rtag == gen_q) && !start_fire;

  hsr_fetch_ctl #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .LONG_W(LONG_W), .GEN_W(GEN_W)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .start_fire(start_fire), .start_long(start_addr[ADDR_W-1:2]),
    .stored(stored_cnt), .rsp_valid(mem_rvalid),
    .req(mem_req), .req_addr(mem_addr), .gen(gen_q), .inflight(inflight_cnt)
  );

  hsr_prefetch_q #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .WIDTH(32)
  ) u_queue (
    .clk(clk), .rst_n(rst_n),
    .flush(start_fire), .push(rsp_push), .push_data(mem_rdata),
    .pop(take_fire && adv_pop),
    .head0(head0), .head1(head1), .stored(stored_cnt)
  );

  hsr_item_align #(.CNT_W(CNT_W)) u_align (
    .head0(head0), .head1(head1), .cursor(cursor_q), .size(take_size),
    .stored(stored_cnt),
    .item(take_data), .zero(take_zero), .msb(take_msb),
    .enough(item_enough), .pop(adv_pop), .next_cursor(cursor_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      cursor_q <= '0;
    else if (start_fire)
      cursor_q <= start_addr[1:0];
    else if (take_fire)
      cursor_q <= cursor_nx;
  end

  assign mem_tag = gen_q;

endmodule

// File: rtl/hsr_checker.sv
module hsr_checker #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4,
  parameter int GEN_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_busy,
  input logic             start_valid,
  input logic             start_ready,
  input logic             start_fire,
  input logic             take_ready,
  input logic             take_fire,
  input logic [1:0]       take_size,
  input logic [31:0]      take_data,
  input logic             take_zero,
  input logic             take_msb,
  input logic             mem_rvalid,
  input logic [GEN_W-1:0] mem_rtag,
  input logic [GEN_W-1:0] gen_q,
  input logic [1:0]       cursor_q,
  input logic [CNT_W-1:0] stored_cnt,
  input logic [CNT_W-1:0] inflight_cnt
);
  import hsr_pkg::*;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((CNT_W+1)'(stored_cnt) + (CNT_W+1)'(inflight_cnt)) <= (CNT_W+1)'(DEPTH)); // R9

  AST_WRITE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && wr_busy) |-> !start_ready); // R2

  AST_FLUSH_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |=> (stored_cnt == '0)); // R3

  AST_STALE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rvalid && mem_rtag != gen_q) |=> (stored_cnt <= $past(stored_cnt))); // R3

  AST_CURSOR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (take_fire && !start_fire) |=> (cursor_q == 2'($past(cursor_q) + 2'($past(item_bytes(take_size)))))); // R4

  AST_BYTE_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ready && take_size == 2'b00) |-> (take_data[31:8] == '0)); // R4

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    take_ready |-> (take_zero == (take_data == '0))); // R6

  AST_MSB_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ready && take_size[1]) |-> (take_msb == take_data[31])); // R7

  AST_HOLD_FOR_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid |-> !take_ready); // R8

endmodule

bind hub_stream_rdport hsr_checker #(
  .DEPTH(DEPTH), .CNT_W(CNT_W), .GEN_W(GEN_W)
) u_hsr_checker (
  .clk(clk), .rst_n(rst_n), .wr_busy(wr_busy),
  .start_valid(start_valid), .start_ready(start_ready), .start_fire(start_fire),
  .take_ready(take_ready), .take_fire(take_fire), .take_size(take_size),
  .take_data(take_data), .take_zero(take_zero), .take_msb(take_msb),
  .mem_rvalid(mem_rvalid), .mem_rtag(mem_rtag), .gen_q(gen_q),
  .cursor_q(cursor_q), .stored_cnt(stored_cnt), .inflight_cnt(inflight_cnt)
);

// File: tb/tb_hub_stream_rdport.sv
module tb_hub_stream_rdport;
  localparam int AW    = 19;
  localparam int LW    = AW - 2;
  localparam int DEPTH = 8;
  localparam int LAT   = 3;
  localparam int GW    = $clog2(LAT + 1) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_busy = 1'b0;
  logic          start_valid = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          start_ready;
  logic          take_valid = 1'b0;
  logic [1:0]    take_size = 2'b00;
  logic          take_ready;
  logic [31:0]   take_data;
  logic          take_zero;
  logic          take_msb;
  logic          mem_req;
  logic [LW-1:0] mem_addr;
  logic [GW-1:0] mem_tag;
  logic          mem_rvalid;
  logic [31:0]   mem_rdata;
  logic [GW-1:0] mem_rtag;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int nreq   = 0;
  logic [AW-1:0] ptr = '0;
  logic          want_first = 1'b0;
  logic          got_first  = 1'b0;
  logic [LW-1:0] first_addr = '0;

  always #5 clk = ~clk;

  hub_stream_rdport #(.ADDR_W(AW), .DEPTH(DEPTH), .RD_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .wr_busy(wr_busy),
    .start_valid(start_valid), .start_addr(start_addr), .start_ready(start_ready),
    .take_valid(take_valid), .take_size(take_size), .take_ready(take_ready),
    .take_data(take_data), .take_zero(take_zero), .take_msb(take_msb),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_tag(mem_tag),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rtag(mem_rtag)
  );

  // memory image defined byte by byte; two of every five bytes are zero
  function automatic logic [7:0] mb(input logic [AW-1:0] b);
    int v;
    v = int'(b);
    if (v % 5 < 2) return 8'h00;
    return 8'((v * 29 + 7) & 255);
  endfunction

  function automatic logic [31:0] mem_long(input logic [LW-1:0] la);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = mb({la, 2'(i)});
    return r;
  endfunction

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
  endfunction

  function automatic logic [31:0] exp_item(input logic [AW-1:0] p, input logic [1:0] sz);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < nbytes(sz); i++) r[8*i +: 8] = mb(p + AW'(i));
    return r;
  endfunction

  // memory model with fixed latency, sampled late in each cycle
  logic          req_s = 1'b0;
  logic [LW-1:0] addr_s = '0;
  logic [GW-1:0] tag_s = '0;
  logic          pv [LAT];
  logic [LW-1:0] pa [LAT];
  logic [GW-1:0] pt [LAT];

  always @(negedge clk) begin
    #3;
    req_s  = mem_req;
    addr_s = mem_addr;
    tag_s  = mem_tag;
    if (rst_n && mem_req) begin
      nreq++;
      if (want_first) begin
        first_addr = mem_addr;
        got_first  = 1'b1;
        want_first = 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    pv[0] <= rst_n && req_s;
    pa[0] <= addr_s;
    pt[0] <= tag_s;
    for (int i = 1; i < LAT; i++) begin
      pv[i] <= rst_n && pv[i-1];
      pa[i] <= pa[i-1];
      pt[i] <= pt[i-1];
    end
  end

  assign mem_rvalid = pv[LAT-1];
  assign mem_rdata  = mem_long(pa[LAT-1]);
  assign mem_rtag   = pt[LAT-1];

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", rq, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  task automatic do_start(input logic [AW-1:0] a);
    @(negedge clk);
    start_valid = 1'b1;
    start_addr  = a;
    #1;
    while (!start_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    start_valid = 1'b0;
    ptr         = a;
    got_first   = 1'b0;
    want_first  = 1'b1;
    #1;
    chk(take_ready == 1'b0, "R8 empty after redirect", 32'(take_ready), 32'h0);
  endtask

  task automatic wait_first(input logic [AW-1:0] a);
    for (int k = 0; k < 10 && !got_first; k++) begin
      @(negedge clk);
      #4;
    end
    chk(got_first && first_addr == a[AW-1:2], "R1 first request address",
        32'(first_addr), 32'(a[AW-1:2]));
  endtask

  task automatic take(input logic [1:0] sz, input string tag);
    logic [31:0] e;
    int n;
    string rq;
    @(negedge clk);
    take_valid = 1'b1;
    take_size  = sz;
    #1;
    while (!take_ready) begin
      @(negedge clk);
      #1;
    end
    n = nbytes(sz);
    e = exp_item(ptr, sz);
    if (tag != "") rq = tag;
    else if (int'(ptr[1:0]) + n > 4) rq = "R5 straddle";
    else rq = "R4 item";
    chk(take_data == e, rq, take_data, e);
    chk(take_zero == (e == 32'h0), "R6 zero flag", 32'(take_zero), 32'(e == 32'h0));
    chk(take_msb == e[8*n-1], "R7 msb flag", 32'(take_msb), 32'(e[8*n-1]));
    @(posedge clk);
    #1;
    take_valid = 1'b0;
    ptr        = ptr + AW'(n);
  endtask

  initial begin
    int base;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    #4;
    // R11 idle after reset
    chk(nreq == 0, "R11 no request before redirect", 32'(nreq), 32'h0);
    chk(take_ready == 1'b0, "R11 nothing to take", 32'(take_ready), 32'h0);
    chk(start_ready == 1'b1, "R11 start ready", 32'(start_ready), 32'h1);

    // R1 / R4 / R5: every offset against every size
    for (int o = 0; o < 12; o++) begin
      for (int s = 0; s < 4; s++) begin
        do_start(AW'(19'h00120 + o));
        wait_first(AW'(19'h00120 + o));
        for (int k = 0; k < 10; k++) take(2'(s), "");
      end
    end

    // mixed sizes walk the cursor through all positions
    for (int o = 0; o < 4; o++) begin
      do_start(AW'(19'h04401 + 7 * o));
      for (int k = 0; k < 24; k++) take(2'((k * 7 + o) % 3), "");
    end

    // R9: fill without consuming, then one pop allows one more request
    do_start(19'h02000);
    base = nreq;
    repeat (30) @(negedge clk);
    #4;
    chk(nreq - base == DEPTH, "R9 requests stop at queue size", 32'(nreq - base), 32'(DEPTH));
    take(2'b10, "R9 first long");
    repeat (10) @(negedge clk);
    #4;
    chk(nreq - base == DEPTH + 1, "R9 refill after pop", 32'(nreq - base), 32'(DEPTH + 1));

    // R3: redirect with a full queue
    do_start(19'h05001);
    wait_first(19'h05001);
    for (int k = 0; k < 6; k++) take(2'(k % 3), "R3 full queue discarded");

    // R3: back-to-back redirects with responses in flight
    do_start(19'h00300);
    do_start(19'h06006);
    for (int k = 0; k < 12; k++) take(2'((k + 1) % 3), "R3 stale responses dropped");
    do_start(19'h00310);
    repeat (2) @(negedge clk);
    do_start(19'h06107);
    for (int k = 0; k < 12; k++) take(2'(k % 3), "R3 late stale responses dropped");

    // R2: redirect held by pending writes
    do_start(19'h00700);
    repeat (20) @(negedge clk);
    wr_busy     = 1'b1;
    start_valid = 1'b1;
    start_addr  = 19'h01236;
    base = nreq;
    for (int k = 0; k < 6; k++) begin
      #1;
      chk(start_ready == 1'b0, "R2 held while writes pend", 32'(start_ready), 32'h0);
      @(negedge clk);
    end
    #4;
    chk(nreq == base, "R2 no request during hold", 32'(nreq - base), 32'h0);
    @(negedge clk);
    wr_busy = 1'b0;
    #1;
    chk(start_ready == 1'b1, "R2 released", 32'(start_ready), 32'h1);
    @(posedge clk);
    #1;
    start_valid = 1'b0;
    ptr         = 19'h01236;
    got_first   = 1'b0;
    want_first  = 1'b1;
    wait_first(19'h01236);
    for (int k = 0; k < 6; k++) take(2'(2 - k % 3), "R2 stream after hold");

    // R10: fetch address wraps at the top of the space
    do_start(19'h7FFFE);
    wait_first(19'h7FFFE);
    take(2'b10, "R10 long across wrap");
    for (int k = 0; k < 4; k++) take(2'b10, "R10 after wrap");

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule